// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is the power management control and status word of a bus-attached peripheral. Software reaches it through a plain write port with byte enables and a read port that always shows the current contents. The word holds a wake status flag, a wake enable bit and a two-bit device power state. When both the flag and the enable are set, an active-low wake output is pulled low. The block also raises a request to power down the physical-layer transceiver while the device sits in the deepest software-visible low-power state without wake enabled.

Two synchronous resets act on the word. Power-on reset clears everything. Bus reset always returns the power state to full power. Whether it also clears the wake flag and the wake enable depends on an auxiliary-power-detect input: while auxiliary power is present, both bits survive a bus reset, so a wake condition can outlive the host's reset. The wake flag follows the level of its source. Software can clear it only once the source has gone away.

Top module: `pm_ctrl_status_reg`

## Requirements
- R1: After power-on reset, `rd_data` is 0x00000000, `wake_n` is 1 and `phy_pd_req` is 0.
- R2: Bits 31:16, 14:9 and 7:2 of `rd_data` always read 0, whatever has been written.
- R3: When `wake_event` is high at a clock edge and no reset is active, bit 15 (wake status) reads 1 after that edge.
- R4: A write with `wr_be[1]`=1 and `wr_data[15]`=1 clears bit 15 at the edge only if `wake_event` is low in that cycle. If `wake_event` is high, the bit stays 1. Writing 0 to bit 15 has no effect.
- R5: Bit 8 (wake enable) takes `wr_data[8]` on a write with `wr_be[1]`=1 and is unchanged when `wr_be[1]`=0.
- R6: `wake_n` is 0 exactly when bits 15 and 8 of `rd_data` are both 1, and 1 otherwise.
- R7: Bits 1:0 (power state: 00 = full power, 11 = deepest low-power) take `wr_data[1:0]` on a write with `wr_be[0]`=1 when the value is 00 or 11. Values 01 and 10 are ignored.
- R8: `phy_pd_req` rises one edge after the power state reads 11 with bit 8 at 0. It falls one edge after the power state reads 00 or bit 8 reads 1.
- R9: A bus reset with `aux_pwr_det`=0 clears bits 15, 8 and 1:0 and `phy_pd_req`.
- R10: A bus reset with `aux_pwr_det`=1 keeps bits 15 and 8, returns bits 1:0 to 00 and clears `phy_pd_req`.
- R11: A power-on reset clears the whole word and `phy_pd_req` whatever the level of `aux_pwr_det`.
- R12: In a cycle with any reset active, writes and `wake_event` have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| aux_pwr_det | input | 1 | High while auxiliary power is present |
| wake_event | input | 1 | Level of the wake event source |
| wr_en | input | 1 | Write strobe for the register |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| wake_n | output | 1 | Active-low wake request |
| phy_pd_req | output | 1 | Transceiver power-down request |

## Verification
The wake event source and a write-one-to-clear of the status flag can land on the same edge. The bench drives both in one cycle and expects the flag to stay set. It then repeats the clear with the source low and expects the flag to drop. Writes and event pulses are also placed in cycles with each kind of bus reset and with power-on reset, and the outcome is judged against a behavioural model that compares all outputs on every clock.

// File: rtl/pmcsr_pkg.sv
package pmcsr_pkg;

    localparam int REG_W      = 32;
    localparam int LANE_W     = 8;
    localparam int STATUS_BIT = 15;
    localparam int ENABLE_BIT = 8;
    localparam int PS_LSB     = 0;
    localparam int PS_W       = 2;

    typedef enum logic [PS_W-1:0] {
        PS_FULL = 2'b00,
        PS_DEEP = 2'b11
    } pstate_e;

    typedef struct packed {
        logic status;
        logic enable;
    } sticky_t;

    typedef struct packed {
        logic            status_w1c;
        logic            enable_wr;
        logic            enable_val;
        logic            ps_try;
        logic            ps_ok;
        logic [PS_W-1:0] ps_val;
    } wr_ctl_t;

    typedef struct packed {
        logic sticky_clr;
        logic sticky_freeze;
        logic state_rst;
    } rst_ctl_t;

    function automatic logic ps_legal(input logic [PS_W-1:0] v);
        return (v == PS_FULL) || (v == PS_DEEP);
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input sticky_t s, input pstate_e p);
        logic [REG_W-1:0] w;
        w = '0;
        w[STATUS_BIT]           = s.status;
        w[ENABLE_BIT]           = s.enable;
        w[PS_LSB +: PS_W]       = p;
        return w;
    endfunction

endpackage

// File: rtl/pm_wr_decode.sv
module pm_wr_decode
    import pmcsr_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic                     wr_en,
    input  logic [DATA_W/LANE_W-1:0] wr_be,
    input  logic [DATA_W-1:0]        wr_data,
    output wr_ctl_t                  ctl
);
    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] masked;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{wr_en & wr_be[l]}};
        end
    endgenerate

    assign masked = wr_data & lane_mask;

    logic unused_masked;
    assign unused_masked = ^{masked[DATA_W-1:STATUS_BIT+1], masked[STATUS_BIT-1:0]};

    always_comb begin
        ctl            = '0;
        ctl.status_w1c = masked[STATUS_BIT];
        ctl.enable_wr  = wr_en & wr_be[ENABLE_BIT/LANE_W];
        ctl.enable_val = wr_data[ENABLE_BIT];
        ctl.ps_try     = wr_en & wr_be[PS_LSB/LANE_W];
        ctl.ps_ok      = ctl.ps_try & ps_legal(wr_data[PS_LSB +: PS_W]);
        ctl.ps_val     = wr_data[PS_LSB +: PS_W];
    end

endmodule

// File: rtl/pm_sticky_bits.sv
module pm_sticky_bits
    import pmcsr_pkg::*;
(
    input  logic     clk,
    input  rst_ctl_t rc,
    input  logic     wake_event,
    input  wr_ctl_t  ctl,
    output sticky_t  q
);
    always_ff @(posedge clk) begin
        if (rc.sticky_clr) begin
            q <= '0;
        end else if (!rc.sticky_freeze) begin
            if (wake_event)
                q.status <= 1'b1;
            else if (ctl.status_w1c)
                q.status <= 1'b0;
            if (ctl.enable_wr)
                q.enable <= ctl.enable_val;
        end
    end

    // R3: an active event sets the status flag
    p_event_sets_r3: assert property (@(posedge clk) disable iff (rc.sticky_clr)
        (wake_event && !rc.sticky_freeze) |=> q.status);

    // R4: clear only takes effect with the source gone
    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (rc.sticky_clr)
        (ctl.status_w1c && !wake_event && !rc.sticky_freeze) |=> !q.status);

    // R10 / R12: frozen bits hold through a bus reset on auxiliary power
    p_freeze_holds_r10: assert property (@(posedge clk) disable iff (rc.sticky_clr)
        rc.sticky_freeze |=> $stable(q));

endmodule

// File: rtl/pm_pstate_ctrl.sv
module pm_pstate_ctrl
    import pmcsr_pkg::*;
(
    input  logic     clk,
    input  rst_ctl_t rc,
    input  logic     enable,
    input  wr_ctl_t  ctl,
    output pstate_e  ps,
    output logic     pd_req
);
    always_ff @(posedge clk) begin
        if (rc.state_rst) begin
            ps     <= PS_FULL;
            pd_req <= 1'b0;
        end else begin
            pd_req <= (ps == PS_DEEP) && !enable;
            if (ctl.ps_ok)
                ps <= pstate_e'(ctl.ps_val);
        end
    end

    // R7: unsupported encodings leave the state alone
    p_bad_state_ignored_r7: assert property (@(posedge clk) disable iff (rc.state_rst)
        (ctl.ps_try && !ctl.ps_ok) |=> $stable(ps));

    // R8: request follows deep state without wake enable
    p_pd_rise_r8: assert property (@(posedge clk) disable iff (rc.state_rst)
        ((ps == PS_DEEP) && !enable) |=> pd_req);

    p_pd_fall_r8: assert property (@(posedge clk) disable iff (rc.state_rst)
        (ps == PS_FULL) |=> !pd_req);

endmodule

// File: rtl/pm_ctrl_status_reg.sv
module pm_ctrl_status_reg
    import pmcsr_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              bus_rst,
    input  logic              aux_pwr_det,
    input  logic              wake_event,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              wake_n,
    output logic              phy_pd_req
);
    rst_ctl_t rc;
    wr_ctl_t  ctl;
    sticky_t  sticky_q;
    pstate_e  ps_q;

    always_comb begin
        rc.sticky_clr    = por_rst | (bus_rst & ~aux_pwr_det);
        rc.sticky_freeze = bus_rst & aux_pwr_det & ~por_rst;
        rc.state_rst     = por_rst | bus_rst;
    end

    pm_wr_decode #(.DATA_W(REG_W)) u_dec (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .ctl     (ctl)
    );

    pm_sticky_bits u_sticky (
        .clk        (clk),
        .rc         (rc),
        .wake_event (wake_event),
        .ctl        (ctl),
        .q          (sticky_q)
    );

    pm_pstate_ctrl u_pstate (
        .clk    (clk),
        .rc     (rc),
        .enable (sticky_q.enable),
        .ctl    (ctl),
        .ps     (ps_q),
        .pd_req (phy_pd_req)
    );

    assign rd_data = pack_word(sticky_q, ps_q);
    assign wake_n  = ~(sticky_q.status & sticky_q.enable);

    // R6: the wake pin agrees with the visible flag and enable
    p_wake_pin_r6: assert property (@(posedge clk) disable iff (por_rst)
        (rd_data[STATUS_BIT] && rd_data[ENABLE_BIT]) == !wake_n);

    // R2: unimplemented fields stay zero
    p_zero_fields_r2: assert property (@(posedge clk) disable iff (por_rst)
        (rd_data[REG_W-1:16] == '0) && (rd_data[14:9] == '0) && (rd_data[7:2] == '0));

endmodule

// File: tb/pm_ctrl_status_reg_bench.sv
`timescale 1ns/1ps
module pm_ctrl_status_reg_bench;
    logic        clk = 1'b0;
    logic        por_rst = 1'b1, bus_rst = 1'b0, aux_pwr_det = 1'b0, wake_event = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        wake_n, phy_pd_req;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_st, m_en, m_pd;
    int m_ps;

    always #2.5 clk = ~clk;

    pm_ctrl_status_reg u_pm_ctrl_status_reg (
        .clk(clk), .por_rst(por_rst), .bus_rst(bus_rst), .aux_pwr_det(aux_pwr_det),
        .wake_event(wake_event), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .wake_n(wake_n), .phy_pd_req(phy_pd_req)
    );

    always @(posedge clk) begin
        bit n_st, n_en, n_pd;
        int n_ps;
        n_st = m_st; n_en = m_en; n_pd = m_pd; n_ps = m_ps;
        if (por_rst) begin
            n_st = 0; n_en = 0; n_pd = 0; n_ps = 0;
        end else if (bus_rst) begin
            n_ps = 0; n_pd = 0;
            if (!aux_pwr_det) begin n_st = 0; n_en = 0; end
        end else begin
            n_pd = (m_ps == 3) && !m_en;
            if (wake_event) n_st = 1;
            else if (wr_en && wr_be[1] && wr_data[15]) n_st = 0;
            if (wr_en && wr_be[1]) n_en = wr_data[8];
            if (wr_en && wr_be[0] && (wr_data[1:0] == 2'b00 || wr_data[1:0] == 2'b11))
                n_ps = int'(wr_data[1:0]);
        end
        m_st = n_st; m_en = n_en; m_pd = n_pd; m_ps = n_ps;
    end

    function automatic logic [31:0] model_word();
        logic [31:0] w = 32'h0;
        w[15] = m_st; w[8] = m_en; w[1:0] = m_ps[1:0];
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (cmp_on && !done) begin
            check(cur_req, rd_data, model_word(), "rd_data");
            check("R6", {31'h0, wake_n}, {31'h0, !(m_st && m_en)}, "wake_n");
            check(cur_req, {31'h0, phy_pd_req}, {31'h0, m_pd}, "phy_pd_req");
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1; wr_be = be; wr_data = d;
        tick();
        wr_en = 0; wr_be = 0; wr_data = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        tick(); tick(); tick();
        por_rst = 0; cmp_on = 1;
        // R1: reset state
        check("R1", rd_data, 32'h0, "reset word");
        check("R1", {31'h0, wake_n}, 32'h1, "reset wake_n");
        check("R1", {31'h0, phy_pd_req}, 32'h0, "reset pd");

        // R2, R5, R7: all ones written
        cur_req = "R2";
        wr(4'hF, 32'hFFFF_FFFF);
        check("R2", rd_data, 32'h0000_0103, "all-ones write");
        tick();

        // R7: unsupported encodings ignored
        cur_req = "R7";
        wr(4'h1, 32'h0000_0001);
        check("R7", {30'h0, rd_data[1:0]}, 32'h3, "state after 01");
        wr(4'h1, 32'h0000_0002);
        check("R7", {30'h0, rd_data[1:0]}, 32'h3, "state after 10");
        wr(4'h1, 32'h0000_0000);
        check("R7", {30'h0, rd_data[1:0]}, 32'h0, "state after 00");

        // R3 / R6: event pulse
        cur_req = "R3";
        wake_event = 1; tick(); wake_event = 0;
        check("R3", {31'h0, rd_data[15]}, 32'h1, "status set");
        check("R6", {31'h0, wake_n}, 32'h0, "wake asserted");

        // R4: clear collides with live event
        cur_req = "R4";
        wake_event = 1; wr(4'h2, 32'h0000_8100); wake_event = 0;
        check("R4", {31'h0, rd_data[15]}, 32'h1, "status held by live source");
        wr(4'h2, 32'h0000_0100);
        check("R4", {31'h0, rd_data[15]}, 32'h1, "writing 0 ignored");
        wr(4'h2, 32'h0000_8100);
        check("R4", {31'h0, rd_data[15]}, 32'h0, "status cleared");
        check("R6", {31'h0, wake_n}, 32'h1, "wake released");

        // R5: byte lane 1 disabled
        cur_req = "R5";
        wr(4'hD, 32'h0000_0000);
        check("R5", {31'h0, rd_data[8]}, 32'h1, "enable kept without lane");
        wr(4'h2, 32'h0000_0000);
        check("R5", {31'h0, rd_data[8]}, 32'h0, "enable cleared");

        // R8: deep state without enable
        cur_req = "R8";
        wr(4'h1, 32'h0000_0003);
        check("R8", {31'h0, phy_pd_req}, 32'h0, "pd one cycle late");
        tick();
        check("R8", {31'h0, phy_pd_req}, 32'h1, "pd asserted");
        tick(); tick();
        wr(4'h1, 32'h0000_0000);
        tick();
        check("R8", {31'h0, phy_pd_req}, 32'h0, "pd released");

        // R10: bus reset on auxiliary power
        cur_req = "R10";
        wr(4'h3, 32'h0000_0103);
        wake_event = 1; tick(); wake_event = 0;
        aux_pwr_det = 1; bus_rst = 1; tick(); bus_rst = 0;
        check("R10", rd_data, 32'h0000_8100, "sticky kept, state reset");

        // R12: write during bus reset
        cur_req = "R12";
        bus_rst = 1; wr(4'hF, 32'h0000_8003); bus_rst = 0;
        check("R12", rd_data, 32'h0000_8100, "write blocked in reset");

        // R9: bus reset without auxiliary power
        cur_req = "R9";
        aux_pwr_det = 0; bus_rst = 1; wake_event = 1; tick(); bus_rst = 0; wake_event = 0;
        check("R9", rd_data, 32'h0, "all cleared");

        // R11: power-on reset with auxiliary power
        cur_req = "R11";
        wr(4'h3, 32'h0000_0103);
        wake_event = 1; tick(); wake_event = 0;
        tick(); tick();
        aux_pwr_det = 1; por_rst = 1; wr(4'hF, 32'h0000_0103); por_rst = 0;
        check("R11", rd_data, 32'h0, "por clears");
        check("R11", {31'h0, phy_pd_req}, 32'h0, "por pd");
        aux_pwr_det = 0;
        tick(); tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule